// File: doc/BRIEF.md
# Acquisition Trigger Scheduler

This block decides the clock cycle in which a multi-key measurement cycle begins. It sends a one-clock `meas_start` pulse to a measurement engine. The engine answers with a one-clock `meas_done` pulse when the cycle is over. Only one cycle is ever in progress at a time.

The scheduler has two trigger families:

- **Internal timer.** The spacing between starts is a programmed number of prescaled ticks, counted from the start of the previous cycle. A period of zero gives free-run, where each cycle follows the previous one at once.
- **External sync pin.** The pin is synchronised inside the block. It is read in one of two methods:
  - Low-level method: cycles run back-to-back while the pin is held low.
  - Rising-edge method: each rising edge buys exactly one cycle.

Choosing the external pin takes one sense input away, so the block also reports how many keys remain usable.

Top module: `acq_trigger_sched`

## Requirements
- R1: While `rst_n` is low, `meas_start` stays 0.
- R2: Timed mode latches period P and prescale D when a cycle starts. When the cycle finishes in time, the next start follows P*(D+1) clocks after the previous start.
- R3: In timed mode, a cycle that outlasts its period is followed by a new start on the clock edge that samples `meas_done`. That start appears one clock after the done pulse.
- R4: Period 0 is free-run. Each new start appears on the clock edge that samples `meas_done`.
- R5: Changing `cycle_period` or `tick_div` does not alter the interval already counting. Both values take effect at the next start.
- R6: `key_count` is 11 in timed mode (`timed_en`=1) and 10 in sync mode (`timed_en`=0).
- R7: `meas_start` is a single-clock pulse. No start is issued while a cycle is in progress, except on the clock that samples that cycle's `meas_done`.
- R8: In sync mode with `sync_edge_sel`=0 (low level), the first start appears 3+LOW_QUAL clocks after `sync_pin` falls. After that, cycles run back-to-back for as long as the pin stays low.
- R9: In the low-level method, a low pulse of LOW_QUAL clocks or shorter starts no cycle. A pulse of LOW_QUAL+1 clocks starts exactly one cycle.
- R10: In the low-level method, when the pin returns high during a cycle, that cycle runs to its done. No further start follows while the pin stays high.
- R11: In sync mode with `sync_edge_sel`=1 (rising edge), an idle block starts once, 3 clocks after `sync_pin` rises. A held low level starts nothing.
- R12: In the rising-edge method, any number of rising edges during a running cycle yields exactly one extra start, issued on the clock that samples `meas_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timed_en | input | 1 | 1 = internal timer, 0 = external sync pin |
| cycle_period | input | PERIOD_W | Start-to-start period in ticks, 0 = free-run |
| tick_div | input | PRESCALE_W | A tick lasts tick_div+1 clocks |
| sync_edge_sel | input | 1 | 0 = low-level method, 1 = rising-edge method |
| sync_pin | input | 1 | Raw external trigger pin, asynchronous |
| meas_done | input | 1 | One-clock end-of-cycle pulse from the engine |
| meas_start | output | 1 | One-clock start pulse to the engine |
| key_count | output | KCNT_W | Number of usable keys |

## Verification
The timed sweep runs every period, prescale and cycle-length combination of a small configuration against the maximum of P*(D+1) and L+1:
- A timer that counted from the end of a cycle would stretch every interval.
- A timer that reread the period mid-count would break the reload test.

Low pulses of exactly LOW_QUAL and LOW_QUAL+1 clocks probe the qualification boundary, where an off-by-one counter shows up as a missing or a spurious start. Raising the pin during a level-mode cycle catches a design that keeps running or cuts the cycle short. Bursts of one to three edges during a long cycle catch a pending flag that counts edges or drops them.

// File: rtl/trig_pkg.sv
// Package: shared types of the acquisition trigger scheduler.
package trig_pkg;
    // Trigger source actually in effect, derived from the mode inputs
    typedef enum logic [1:0] {
        SRC_TIMED     = 2'd0,
        SRC_SYNC_LOW  = 2'd1,
        SRC_SYNC_RISE = 2'd2
    } trig_src_e;
endpackage

// File: rtl/trig_sync_front.sv
// trig_sync_front
//   Brings the asynchronous sync pin into the clock domain through two
//   flops. A third flop delays the synchronised level for edge detection.
//   A saturating counter qualifies a low level that has lasted LOW_QUAL
//   clocks.
//   Assumes: pin is asynchronous; LOW_QUAL >= 1.
module trig_sync_front #(
    parameter int LOW_QUAL = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic rise_o,
    output logic low_ok_o
);
    localparam int LQ_W = $clog2(LOW_QUAL + 1);

    logic          meta_q;
    logic          lvl_q;
    logic          lvl_d1_q;
    logic [LQ_W-1:0] low_cnt_q;

    // Synchroniser chain plus delay stage; reset value is "high" so a
    // low pin must be seen for the full window before it counts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= 1'b1;
            lvl_q    <= 1'b1;
            lvl_d1_q <= 1'b1;
        end else begin
            meta_q   <= pin_raw;
            lvl_q    <= meta_q;
            lvl_d1_q <= lvl_q;
        end
    end

    // Count consecutive low clocks, saturating at the qualification length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (lvl_q) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != LQ_W'(LOW_QUAL)) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    // Edge and qualified-low flags for the controller
    always_comb begin
        rise_o   = lvl_q & ~lvl_d1_q;
        low_ok_o = ~lvl_q & (low_cnt_q == LQ_W'(LOW_QUAL));
    end
endmodule

// File: rtl/trig_period_timer.sv
// trig_period_timer
//   Measures the interval since the last cycle start in prescaled ticks.
//   A tick lasts div+1 clocks. The period and prescale are captured only
//   at reload (cycle start). due_o is raised in the clock whose edge
//   completes the period, and stays high until the next reload. A
//   captured period of 0 keeps due_o high (free-run).
//   Assumes: reload_i is a single-clock pulse issued at cycle start.
module trig_period_timer #(
    parameter int PERIOD_W   = 8,
    parameter int PRESCALE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reload_i,
    input  logic [PERIOD_W-1:0]   period_i,
    input  logic [PRESCALE_W-1:0] div_i,
    output logic                  due_o
);
    logic [PERIOD_W-1:0]   per_q;
    logic [PERIOD_W-1:0]   elapsed_q;
    logic [PRESCALE_W-1:0] div_q;
    logic [PRESCALE_W-1:0] pre_q;
    logic                  tick;
    logic                  reached;
    logic                  last_tick;

    // Tick strobe and interval comparisons
    always_comb begin
        tick      = (pre_q == div_q);
        reached   = (elapsed_q == per_q);
        last_tick = tick &
                    (((PERIOD_W+1)'(elapsed_q) + (PERIOD_W+1)'(1)) == (PERIOD_W+1)'(per_q));
        due_o     = reached | last_tick;
    end

    // Capture settings at start, then run prescaler and saturating tick count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q     <= '0;
            div_q     <= '0;
            elapsed_q <= '0;
            pre_q     <= '0;
        end else if (reload_i) begin
            per_q     <= period_i;
            div_q     <= div_i;
            elapsed_q <= '0;
            pre_q     <= '0;
        end else if (tick) begin
            pre_q <= '0;
            if (!reached) begin
                elapsed_q <= elapsed_q + 1'b1;
            end
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/trig_sched_ctrl.sv
// trig_sched_ctrl
//   Arbitrates trigger requests against the single measurement engine.
//   A start fires when the engine is idle, or is finishing in this clock,
//   and the selected source asks for a cycle. A rising edge that cannot
//   be served at once is held in a one-bit pending flag, so edges seen
//   during a run merge into one.
//   Assumes: done_i is a one-clock pulse per started cycle.
module trig_sched_ctrl
    import trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  trig_src_e src_i,
    input  logic      due_i,
    input  logic      low_ok_i,
    input  logic      rise_i,
    input  logic      done_i,
    output logic      fire_o,
    output logic      start_o,
    output logic      pend_o
);
    logic busy_q;
    logic pend_q;
    logic want;

    // Request from the source in effect
    always_comb begin
        unique case (src_i)
            SRC_TIMED:     want = due_i;
            SRC_SYNC_LOW:  want = low_ok_i;
            SRC_SYNC_RISE: want = rise_i | pend_q;
            default:       want = 1'b0;
        endcase
        fire_o = want & (~busy_q | done_i);
        pend_o = pend_q;
    end

    // Busy tracking, registered start pulse and pending edge flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            start_o <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            start_o <= fire_o;
            if (fire_o) begin
                busy_q <= 1'b1;
            end else if (done_i) begin
                busy_q <= 1'b0;
            end
            if (src_i == SRC_SYNC_RISE) begin
                pend_q <= (pend_q | rise_i) & ~fire_o;
            end else begin
                pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/acq_trigger_sched.sv
// acq_trigger_sched
//   Top of the acquisition trigger scheduler. It selects the trigger
//   source from the mode inputs, ties the sync front end, the period
//   timer and the start controller together, and reports the usable key
//   count (one sense input is lost to the sync pin in sync mode).
//   Assumes: the engine answers every start with one done pulse.
module acq_trigger_sched
    import trig_pkg::*;
#(
    parameter int PERIOD_W   = 8,
    parameter int PRESCALE_W = 8,
    parameter int LOW_QUAL   = 16,
    parameter int NUM_SENSE  = 11,
    parameter int KCNT_W     = $clog2(NUM_SENSE + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  timed_en,
    input  logic [PERIOD_W-1:0]   cycle_period,
    input  logic [PRESCALE_W-1:0] tick_div,
    input  logic                  sync_edge_sel,
    input  logic                  sync_pin,
    input  logic                  meas_done,
    output logic                  meas_start,
    output logic [KCNT_W-1:0]     key_count
);
    trig_src_e src;
    logic      sync_rise;
    logic      low_ok;
    logic      due;
    logic      fire;
    logic      pend;

    // Decode the source in effect and the key count it leaves
    always_comb begin
        if (timed_en) begin
            src       = SRC_TIMED;
            key_count = KCNT_W'(NUM_SENSE);
        end else begin
            src       = sync_edge_sel ? SRC_SYNC_RISE : SRC_SYNC_LOW;
            key_count = KCNT_W'(NUM_SENSE - 1);
        end
    end

    trig_sync_front #(
        .LOW_QUAL (LOW_QUAL)
    ) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (sync_pin),
        .rise_o   (sync_rise),
        .low_ok_o (low_ok)
    );

    trig_period_timer #(
        .PERIOD_W   (PERIOD_W),
        .PRESCALE_W (PRESCALE_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (fire),
        .period_i (cycle_period),
        .div_i    (tick_div),
        .due_o    (due)
    );

    trig_sched_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src),
        .due_i    (due),
        .low_ok_i (low_ok),
        .rise_i   (sync_rise),
        .done_i   (meas_done),
        .fire_o   (fire),
        .start_o  (meas_start),
        .pend_o   (pend)
    );
endmodule

// File: rtl/trig_sched_checker.sv
// trig_sched_checker
//   Temporal properties of the scheduler, bound into acq_trigger_sched.
//   It keeps its own view of whether a cycle is in progress, built from
//   the start and done pulses at the ports.
module trig_sched_checker (
    input logic clk,
    input logic rst_n,
    input logic timed_en,
    input logic sync_edge_sel,
    input logic meas_start,
    input logic meas_done,
    input logic due,
    input logic low_ok,
    input logic sync_rise,
    input logic pend
);
    logic ck_busy;

    // Port-level cycle tracking; done closes the cycle it belongs to
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_busy <= 1'b0;
        end else if (meas_done) begin
            ck_busy <= 1'b0;
        end else if (meas_start) begin
            ck_busy <= 1'b1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !meas_start);

    a_r7_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_start && !meas_done) |=> !meas_start);

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start |-> !ck_busy);

    a_r2_not_before_due: assert property (@(posedge clk) disable iff (!rst_n)
        (timed_en && !due) |=> !meas_start);

    a_r10_level_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!timed_en && !sync_edge_sel && !low_ok) |=> !meas_start);

    a_r12_edge_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!timed_en && sync_edge_sel && !sync_rise && !pend) |=> !meas_start);
endmodule

bind acq_trigger_sched trig_sched_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .timed_en      (timed_en),
    .sync_edge_sel (sync_edge_sel),
    .meas_start    (meas_start),
    .meas_done     (meas_done),
    .due           (due),
    .low_ok        (low_ok),
    .sync_rise     (sync_rise),
    .pend          (pend)
);

// File: tb/sim_acq_trigger_sched.sv
// Bench: sweeps timed configurations and sync-pin scenarios against
// arithmetic expectations; a behavioural engine answers each start.
module sim_acq_trigger_sched;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 6;
    localparam int DW = 3;
    localparam int LQ = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          timed_en = 1'b1;
    logic [PW-1:0] cycle_period = '0;
    logic [DW-1:0] tick_div = '0;
    logic          sync_edge_sel = 1'b0;
    logic          sync_pin = 1'b0;
    logic          meas_done = 1'b0;
    logic          meas_start;
    logic [3:0]    key_count;

    acq_trigger_sched #(
        .PERIOD_W   (PW),
        .PRESCALE_W (DW),
        .LOW_QUAL   (LQ)
    ) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .timed_en      (timed_en),
        .cycle_period  (cycle_period),
        .tick_div      (tick_div),
        .sync_edge_sel (sync_edge_sel),
        .sync_pin      (sync_pin),
        .meas_done     (meas_done),
        .meas_start    (meas_start),
        .key_count     (key_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int   nstarts = 0;
    int   t_prev = 0;
    int   t_last = 0;
    int   eng_len = 2;
    int   rem = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    event ev_start;

    // Monitor and engine model: done arrives eng_len clocks after a start
    initial begin
        forever begin
            @(negedge clk);
            meas_done = 1'b0;
            if (meas_start) begin
                t_prev = t_last;
                t_last = cyc;
                nstarts++;
                rem = eng_len;
                -> ev_start;
            end else if (rem > 0) begin
                rem--;
                if (rem == 0) meas_done = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_starts(input int n);
        int tgt;
        tgt = nstarts + n;
        while (nstarts < tgt) @(ev_start);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: counts as a failed check and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n0;
        int c0;
        int s0;
        int ps[6] = '{0, 1, 2, 3, 5, 9};
        int ls[2] = '{2, 5};

        // R1, R6: quiet and key count during reset
        repeat (4) begin
            @(negedge clk);
            check(meas_start == 1'b0, "R1 reset start", int'(meas_start), 0);
        end
        check(key_count == 4'd11, "R6 timed keys", int'(key_count), 11);
        rst_n = 1'b1;

        // R2/R3/R4: sweep of period, prescale and engine length
        foreach (ps[i]) begin
            for (int d = 0; d < 3; d++) begin
                foreach (ls[j]) begin
                    int exp;
                    cycle_period = PW'(ps[i]);
                    tick_div = DW'(d);
                    eng_len = ls[j];
                    wait_starts(2);
                    exp = ps[i] * (d + 1);
                    if (exp < ls[j] + 1) exp = ls[j] + 1;
                    if (ps[i] == 0)
                        check(t_last - t_prev == exp, "R4 free-run spacing", t_last - t_prev, exp);
                    else if (ps[i] * (d + 1) < ls[j] + 1)
                        check(t_last - t_prev == exp, "R3 overrun spacing", t_last - t_prev, exp);
                    else
                        check(t_last - t_prev == exp, "R2 timed spacing", t_last - t_prev, exp);
                end
            end
        end

        // R5: new period only after the next start
        cycle_period = PW'(6);
        tick_div = '0;
        eng_len = 2;
        wait_starts(2);
        cycle_period = PW'(2);
        wait_starts(1);
        check(t_last - t_prev == 6, "R5 old period kept", t_last - t_prev, 6);
        wait_starts(1);
        check(t_last - t_prev == 3, "R5 new period used", t_last - t_prev, 3);

        // Low-level sync mode
        sync_pin = 1'b1;
        idle(5);
        timed_en = 1'b0;
        sync_edge_sel = 1'b0;
        eng_len = 4;
        idle(40);
        check(key_count == 4'd10, "R6 sync keys", int'(key_count), 10);
        n0 = nstarts;
        idle(30);
        check(nstarts == n0, "R10 high level idle", nstarts - n0, 0);

        // R9: qualification boundary
        n0 = nstarts;
        sync_pin = 1'b0;
        idle(LQ);
        sync_pin = 1'b1;
        idle(20);
        check(nstarts == n0, "R9 short low ignored", nstarts - n0, 0);
        n0 = nstarts;
        sync_pin = 1'b0;
        idle(LQ + 1);
        sync_pin = 1'b1;
        idle(30);
        check(nstarts == n0 + 1, "R9 just long enough", nstarts - n0, 1);

        // R8: latency and back-to-back running
        c0 = cyc;
        sync_pin = 1'b0;
        wait_starts(1);
        check(t_last - c0 == 3 + LQ, "R8 first latency", t_last - c0, 3 + LQ);
        wait_starts(1);
        check(t_last - t_prev == eng_len + 1, "R8 back-to-back", t_last - t_prev, eng_len + 1);
        wait_starts(1);
        check(t_last - t_prev == eng_len + 1, "R8 back-to-back again", t_last - t_prev, eng_len + 1);

        // R10: raise during a cycle; it finishes, nothing follows
        wait_starts(1);
        sync_pin = 1'b1;
        n0 = nstarts;
        idle(40);
        check(nstarts == n0, "R10 stop after high", nstarts - n0, 0);
        check(rem == 0, "R10 running cycle finished", rem, 0);

        // R11: rising-edge method
        sync_edge_sel = 1'b1;
        sync_pin = 1'b0;
        idle(30);
        n0 = nstarts;
        idle(30);
        check(nstarts == n0, "R11 low level ignored", nstarts - n0, 0);
        for (int k = 0; k < 4; k++) begin
            c0 = cyc;
            sync_pin = 1'b1;
            wait_starts(1);
            check(t_last - c0 == 3, "R11 edge latency", t_last - c0, 3);
            idle(eng_len + 5);
            sync_pin = 1'b0;
            idle(6);
            check(nstarts == n0 + k + 1, "R11 one start per edge", nstarts - n0, k + 1);
        end

        // R12: edges during a long cycle merge into one pending start
        eng_len = 20;
        for (int extra = 1; extra <= 3; extra++) begin
            n0 = nstarts;
            sync_pin = 1'b1;
            wait_starts(1);
            s0 = t_last;
            for (int e = 0; e < extra; e++) begin
                idle(2);
                sync_pin = 1'b0;
                idle(2);
                sync_pin = 1'b1;
            end
            idle(2);
            sync_pin = 1'b0;
            wait_starts(1);
            check(t_last - s0 == eng_len + 1, "R12 pending at done", t_last - s0, eng_len + 1);
            idle(60);
            check(nstarts == n0 + 2, "R12 merged count", nstarts - n0, 2);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule